// File: doc/BRIEF.md
# TLB Refill Victim Selector and Fault Capture

This block chooses which way of a four-way set-associative translation buffer receives the next refill. The choice comes from a 16-bit pseudo-random shift register that moves one step to the right on every real translation fault. Lookups made on behalf of a debug probe leave it untouched.

When a real fault is strobed, the block also records its details in two registers that software reads. The select register holds the set index and the chosen way, and software uses it to place the refill entry. The cause register holds the process ID, the kind of access and the faulting virtual page number. Software may also write the select register directly. A real fault in the same cycle wins over that write.

The translation storage, the lookup itself and exception dispatch are handled elsewhere. This block only sees a fault strobe together with the faulting access's attributes.

Top module: `refill_victim_capture`

## Requirements
- R1: After reset the shift register holds 0xCCCC, so `way_o` reads 0; `sel_o` and `cause_o` read all zeros.
- R2: Each step of the shift register shifts it right by one bit. The new bit 15 is the XOR of the state bits selected by the mask 0x8805 (bits 15, 11, 2 and 0).
- R3: The shift register takes exactly one step in each cycle where `fault_i` is 1 and `probe_i` is 0. It does not move in any other cycle, including cycles where `fault_i` and `probe_i` are both 1.
- R4: `way_o` is combinational and equals bits [1:0] of the shift register. A capturing fault therefore records the value from before that fault's step.
- R5: On a capturing fault, `sel_o` is rewritten in full on the next clock edge. Bits [3:0] take `vpn_i` mod 16, bits [5:4] take `way_o`, and no other bits exist.
- R6: On a capturing fault, `cause_o` takes `pid_i` in bits [7:0], `kind_i` in bits [9:8] and `vpn_i` in bits [31:13]. The access-kind codes are 0 for read, 1 for write and 2 for execute.
- R7: Bits [12:10] of `cause_o` are never written by a fault and keep their previous value, which is zero after reset.
- R8: With `sel_wr_i` at 1 and no capturing fault, `sel_o` takes `sel_wdata_i` on the next edge. A capturing fault in the same cycle overrides the write.
- R9: A cycle with neither a capturing fault nor a select write leaves `sel_o`, `cause_o` and the shift register unchanged. This includes a probe-flagged fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fault_i | input | 1 | Fault strobe, one per faulting lookup |
| probe_i | input | 1 | The lookup came from a debug probe; suppresses capture |
| vpn_i | input | 19 | Faulting virtual page number |
| pid_i | input | 8 | Current process ID |
| kind_i | input | 2 | Access kind: 0 read, 1 write, 2 execute |
| sel_wr_i | input | 1 | Software write strobe for the select register |
| sel_wdata_i | input | 6 | Software write data for the select register |
| way_o | output | 2 | Way chosen for the next refill |
| sel_o | output | 6 | Select register: {way, set index} |
| cause_o | output | 32 | Cause register |

## Verification
The main test walks a table of faults. The table mixes all three access kinds, page numbers whose low four bits differ while the upper bits match, and page numbers that are all ones or all zeros, so any misplaced field shows up in a different bit. Probe-flagged faults are placed between real ones, so a register that steps on a probe makes every later way in the sequence wrong. Long runs of faults test that the predicted way sequence matches the tap polynomial and the seed. Directed cases set a software write against a fault in the same cycle, and check that idle cycles leave all state in place.

// File: rtl/rvc_pkg.sv
package rvc_pkg;
  typedef enum logic [1:0] {
    ACC_READ  = 2'd0,
    ACC_WRITE = 2'd1,
    ACC_EXEC  = 2'd2
  } acc_kind_e;

  // XOR-reduce of the state bits picked by a tap mask
  function automatic logic tap_parity(input logic [15:0] st, input logic [15:0] taps);
    return ^(st & taps);
  endfunction
endpackage

// File: rtl/rvc_lfsr.sv
module rvc_lfsr #(
  parameter int          LFSR_W = 16,
  parameter logic [15:0] SEED   = 16'hCCCC,
  parameter logic [15:0] TAPS   = 16'h8805
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step_i,
  output logic [LFSR_W-1:0] state_o
);
  logic [LFSR_W-1:0] st_q, st_d;

  always_comb begin
    st_d = st_q;
    if (step_i) st_d = {rvc_pkg::tap_parity(st_q, TAPS), st_q[LFSR_W-1:1]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= SEED;
    else        st_q <= st_d;
  end

  assign state_o = st_q;

  // R2
  shift_right_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step_i |=> st_q[LFSR_W-2:0] == $past(st_q[LFSR_W-1:1]));
  // R3
  hold_no_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !step_i |=> $stable(st_q));
endmodule

// File: rtl/rvc_sel_reg.sv
module rvc_sel_reg #(
  parameter int IDX_W = 4,
  parameter int WAY_W = 2,
  localparam int SEL_W = IDX_W + WAY_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cap_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic [WAY_W-1:0] way_i,
  input  logic             wr_i,
  input  logic [SEL_W-1:0] wdata_i,
  output logic [SEL_W-1:0] sel_o
);
  logic [SEL_W-1:0] sel_q, sel_d;
  logic             sel_en;

  always_comb begin
    sel_en = cap_i | wr_i;
    if (cap_i) sel_d = {way_i, idx_i};
    else       sel_d = wdata_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      sel_q <= '0;
    else if (sel_en) sel_q <= sel_d;
  end

  assign sel_o = sel_q;

  // R5
  sel_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cap_i |=> sel_q == {$past(way_i), $past(idx_i)});
  // R8
  sel_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && !cap_i) |=> sel_q == $past(wdata_i));
  // R9
  sel_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_i && !cap_i) |=> $stable(sel_q));
endmodule

// File: rtl/rvc_cause_reg.sv
module rvc_cause_reg #(
  parameter int PID_W  = 8,
  parameter int KIND_W = 2,
  parameter int VPN_W  = 19,
  parameter int VPN_LSB = 13,
  localparam int KIND_LSB = PID_W,
  localparam int CAUSE_W  = VPN_LSB + VPN_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cap_i,
  input  logic [PID_W-1:0]   pid_i,
  input  logic [KIND_W-1:0]  kind_i,
  input  logic [VPN_W-1:0]   vpn_i,
  output logic [CAUSE_W-1:0] cause_o
);
  logic [CAUSE_W-1:0] cause_q, cause_d;

  always_comb begin
    cause_d = cause_q;
    cause_d[PID_W-1:0]                 = pid_i;
    cause_d[KIND_LSB +: KIND_W]        = kind_i;
    cause_d[CAUSE_W-1:VPN_LSB]         = vpn_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cause_q <= '0;
    else if (cap_i) cause_q <= cause_d;
  end

  assign cause_o = cause_q;

  // R6
  cause_fields_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cap_i |=> (cause_q[CAUSE_W-1:VPN_LSB] == $past(vpn_i)) &&
              (cause_q[PID_W-1:0] == $past(pid_i)));
  // R7
  cause_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> $stable(cause_q[VPN_LSB-1:KIND_LSB+KIND_W]));
  // R9
  cause_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_i |=> $stable(cause_q));
endmodule

// File: rtl/refill_victim_capture.sv
module refill_victim_capture #(
  parameter int          LFSR_W  = 16,
  parameter logic [15:0] SEED    = 16'hCCCC,
  parameter logic [15:0] TAPS    = 16'h8805,
  parameter int          IDX_W   = 4,
  parameter int          WAY_W   = 2,
  parameter int          PID_W   = 8,
  parameter int          KIND_W  = 2,
  parameter int          VPN_W   = 19,
  parameter int          VPN_LSB = 13,
  localparam int         SEL_W   = IDX_W + WAY_W,
  localparam int         CAUSE_W = VPN_LSB + VPN_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               fault_i,
  input  logic               probe_i,
  input  logic [VPN_W-1:0]   vpn_i,
  input  logic [PID_W-1:0]   pid_i,
  input  logic [KIND_W-1:0]  kind_i,
  input  logic               sel_wr_i,
  input  logic [SEL_W-1:0]   sel_wdata_i,
  output logic [WAY_W-1:0]   way_o,
  output logic [SEL_W-1:0]   sel_o,
  output logic [CAUSE_W-1:0] cause_o
);
  logic              cap;
  logic [LFSR_W-1:0] rnd;

  assign cap   = fault_i & ~probe_i;
  assign way_o = rnd[WAY_W-1:0];

  rvc_lfsr #(.LFSR_W(LFSR_W), .SEED(SEED), .TAPS(TAPS)) u_lfsr (
    .clk(clk), .rst_n(rst_n), .step_i(cap), .state_o(rnd)
  );

  rvc_sel_reg #(.IDX_W(IDX_W), .WAY_W(WAY_W)) u_sel (
    .clk(clk), .rst_n(rst_n), .cap_i(cap), .idx_i(vpn_i[IDX_W-1:0]),
    .way_i(rnd[WAY_W-1:0]), .wr_i(sel_wr_i), .wdata_i(sel_wdata_i), .sel_o(sel_o)
  );

  rvc_cause_reg #(.PID_W(PID_W), .KIND_W(KIND_W), .VPN_W(VPN_W), .VPN_LSB(VPN_LSB)) u_cause (
    .clk(clk), .rst_n(rst_n), .cap_i(cap), .pid_i(pid_i), .kind_i(kind_i),
    .vpn_i(vpn_i), .cause_o(cause_o)
  );

  // R4
  way_recorded_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cap |=> sel_o[SEL_W-1:IDX_W] == $past(way_o));
  // R3
  probe_no_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_i && probe_i) |=> $stable(cause_o) && $stable(way_o));
endmodule

// File: tb/refill_victim_capture_tb.sv
module refill_victim_capture_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 10;
  // {probe, kind[1:0], pid[7:0], vpn[18:0]}
  localparam logic [29:0] VEC [NVEC] = '{
    {1'b0, 2'd0, 8'h5A, 19'h12345},
    {1'b0, 2'd1, 8'hA5, 19'h12346},
    {1'b1, 2'd2, 8'hFF, 19'h7FFFF},
    {1'b0, 2'd2, 8'h01, 19'h7FFFF},
    {1'b0, 2'd0, 8'h00, 19'h00000},
    {1'b1, 2'd1, 8'h33, 19'h0000F},
    {1'b0, 2'd1, 8'hFF, 19'h4000A},
    {1'b0, 2'd2, 8'h80, 19'h2AAAA},
    {1'b0, 2'd0, 8'h7E, 19'h55555},
    {1'b0, 2'd1, 8'h11, 19'h00007}
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic        fault_i, probe_i, sel_wr_i;
  logic [18:0] vpn_i;
  logic [7:0]  pid_i;
  logic [1:0]  kind_i;
  logic [5:0]  sel_wdata_i;
  logic [1:0]  way_o;
  logic [5:0]  sel_o;
  logic [31:0] cause_o;

  int checks = 0;
  int errors = 0;
  logic [15:0] m_lfsr;
  logic [5:0]  m_sel;
  logic [31:0] m_cause;

  always #(CLK_PERIOD/2) clk = ~clk;

  refill_victim_capture dut_i (
    .clk(clk), .rst_n(rst_n), .fault_i(fault_i), .probe_i(probe_i),
    .vpn_i(vpn_i), .pid_i(pid_i), .kind_i(kind_i), .sel_wr_i(sel_wr_i),
    .sel_wdata_i(sel_wdata_i), .way_o(way_o), .sel_o(sel_o), .cause_o(cause_o)
  );

  function automatic logic [15:0] step_model(input logic [15:0] s);
    logic fb;
    fb = s[15] ^ s[11] ^ s[2] ^ s[0];
    return {fb, s[15:1]};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic check_all(input string req);
    chk({req, " way"}, {30'd0, way_o}, {30'd0, m_lfsr[1:0]});
    chk({req, " sel"}, {26'd0, sel_o}, {26'd0, m_sel});
    chk({req, " cause"}, cause_o, m_cause);
  endtask

  // drive at negedge, clock once, update model, return at next negedge
  task automatic cycle(input logic f, input logic p, input logic [1:0] k,
                       input logic [7:0] pid, input logic [18:0] vpn,
                       input logic wr, input logic [5:0] wd);
    fault_i = f; probe_i = p; kind_i = k; pid_i = pid; vpn_i = vpn;
    sel_wr_i = wr; sel_wdata_i = wd;
    #1;
    chk("R4 way before edge", {30'd0, way_o}, {30'd0, m_lfsr[1:0]});
    if (f && !p) begin
      m_sel = {m_lfsr[1:0], vpn[3:0]};
      m_cause = {vpn, m_cause[12:10], k, pid};
      m_lfsr = step_model(m_lfsr);
    end else if (wr) begin
      m_sel = wd;
    end
    @(posedge clk);
    @(negedge clk);
    fault_i = 1'b0; sel_wr_i = 1'b0; probe_i = 1'b0;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; fault_i = 0; probe_i = 0; sel_wr_i = 0;
    vpn_i = '0; pid_i = '0; kind_i = '0; sel_wdata_i = '0;
    m_lfsr = 16'hCCCC; m_sel = '0; m_cause = '0;
    repeat (3) @(negedge clk);
    check_all("R1 reset");
    rst_n = 1'b1;
    @(negedge clk);
    check_all("R1 after release");

    // table walk: R2 R3 R5 R6 R7
    for (int i = 0; i < NVEC; i++) begin
      cycle(1'b1, VEC[i][29], VEC[i][28:27], VEC[i][26:19], VEC[i][18:0], 1'b0, 6'd0);
      check_all(VEC[i][29] ? "R3 probe ignored" : "R5 R6 capture");
      chk("R7 gap bits", {29'd0, cause_o[12:10]}, 32'd0);
    end

    // R9: idle cycles hold everything
    cycle(1'b0, 1'b0, 2'd2, 8'hEE, 19'h7ABCD, 1'b0, 6'd0);
    cycle(1'b0, 1'b0, 2'd1, 8'h12, 19'h00001, 1'b0, 6'd0);
    check_all("R9 idle hold");

    // R8: software write alone
    cycle(1'b0, 1'b0, 2'd0, 8'h00, 19'h0, 1'b1, 6'h2B);
    check_all("R8 sw write");
    chk("R8 sel value", {26'd0, sel_o}, 32'h2B);

    // R8: fault wins over write
    cycle(1'b1, 1'b0, 2'd2, 8'hC3, 19'h1234C, 1'b1, 6'h3F);
    check_all("R8 fault priority");

    // R8/R9: probe fault does not block the write
    cycle(1'b1, 1'b1, 2'd1, 8'h99, 19'h00003, 1'b1, 6'h15);
    check_all("R9 probe with write");

    // R2: long run of real faults, way sequence against model
    for (int n = 0; n < 200; n++) begin
      cycle(1'b1, 1'b0, 2'(n % 3), 8'(n), 19'(n * 97), 1'b0, 6'd0);
      check_all("R2 long sequence");
    end

    // R1: reset mid-run restores seed and clears registers
    rst_n = 1'b0;
    m_lfsr = 16'hCCCC; m_sel = '0; m_cause = '0;
    #1;
    check_all("R1 async reset");
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    cycle(1'b1, 1'b0, 2'd1, 8'h44, 19'h00009, 1'b0, 6'd0);
    check_all("R1 R4 first fault after reset");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule